// File: doc/BRIEF.md
# Flash Unlock-Sequence Command Decoder

This block sits on the shared write path of a flash bank. It watches each bus write cycle, which is a pair of address and data, and tracks the multi-cycle unlock sequences. When a sequence completes, the block issues a one-cycle start pulse for a word program, a sector erase, a block erase or a whole-array erase. With the pulse it presents the operation kind, the latched target address and the latched data word. A separate branch of the same sequence turns an identification mode on or off. While that mode is active, reads return a fixed manufacturer code or a device code.

Each write is qualified from the bank enable, the write strobe and the output enable. These are sampled on the block clock. The address is captured when the write condition begins, and the data when it ends. The sequence step is evaluated at the end of the write. If a write does not fit the expected step, the decoder drops back to plain read mode. While the external program or erase timer reports busy, every write is ignored.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write counts only while bank enable is low, write strobe is low and output enable is high. The address is taken in the first cycle of that condition, the data in its last cycle, and the step is evaluated in the first cycle after the condition ends. A write with output enable low or bank enable high has no effect.
- R2: Every sequence begins with low byte AAh at address 5555h, then low byte 55h at address 2AAAh. Only address bits 14..0 and data bits 7..0 are compared, so the upper data byte and address bits 15 and up are ignored.
- R3: A third write of A0h at 5555h arms a program. The next write raises op_start_o with op_kind_o=0, op_addr_o set to that write's full address and op_data_o set to its full data word.
- R4: A third write of 80h at 5555h, then AAh at 5555h and 55h at 2AAAh, arms an erase. The sixth write selects the erase. 10h at 5555h gives op_kind_o=3 with op_addr_o=0. 30h gives op_kind_o=1 with address bits 10..0 cleared. 50h gives op_kind_o=2 with address bits 14..0 cleared.
- R5: A third write of 90h at 5555h sets id_mode_o. While id_mode_o is set, id_rdata_o is 00BFh when bus_addr bit 0 is 0 and DEV_CODE (default 2780h) when it is 1. When id_mode_o is clear, id_rdata_o is 0.
- R6: id_mode_o clears on the three-write sequence that ends with F0h at 5555h. It also clears on a single write with low byte F0h to any address, in any state except the program target write.
- R7: Any write that does not match the expected step returns the decoder to its idle state and clears id_mode_o. It starts no operation.
- R8: While busy_i is high, completed writes change neither the sequence state nor id_mode_o, and they start nothing.
- R9: After reset op_start_o and id_mode_o are 0 and the decoder is idle; identification mode does not survive a reset.
- R10: op_start_o is high for exactly one cycle per completed sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Flash bank enable, active low |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| busy_i | input | 1 | Program or erase in progress |
| op_start_o | output | 1 | One-cycle operation start |
| op_kind_o | output | 2 | 0 program, 1 sector, 2 block, 3 whole array |
| op_addr_o | output | AW | Latched target address, aligned for erase |
| op_data_o | output | DW | Latched program data |
| id_mode_o | output | 1 | Identification mode active |
| id_rdata_o | output | DW | Identification read data |

## Verification
The assertions assume that busy_i is low through reset and that a write condition lasts at least one full clock, so a released strobe is seen before the next write begins. The stimulus drives each strobe low for two cycles and releases it for at least one cycle before the next write. It changes inputs only on the falling clock edge. It raises busy_i only between writes, never while a write condition is active.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter logic [15:0] DEV_CODE = 16'h2780,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_ce_n,
  input  logic          bus_we_n,
  input  logic          bus_oe_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          busy_i,
  output logic          op_start_o,
  output logic [1:0]    op_kind_o,
  output logic [AW-1:0] op_addr_o,
  output logic [DW-1:0] op_data_o,
  output logic          id_mode_o,
  output logic [DW-1:0] id_rdata_o
);
  localparam logic [2:0] S_IDLE = 3'd0, S_C1 = 3'd1, S_C2 = 3'd2, S_PGM = 3'd3,
                         S_E3 = 3'd4, S_E4 = 3'd5, S_E5 = 3'd6;

  logic          wr_act, wr_q, commit;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic [2:0]    st;
  logic [7:0]    lo;
  logic          at5, at2;

  assign wr_act = !bus_ce_n && !bus_we_n && bus_oe_n;
  assign commit = wr_q && !wr_act;
  assign lo     = d_q[7:0];
  assign at5    = a_q[14:0] == 15'h5555;
  assign at2    = a_q[14:0] == 15'h2AAA;

  assign id_rdata_o = !id_mode_o ? '0 :
                      bus_addr[0] ? DW'(DEV_CODE) : DW'(16'h00BF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      a_q  <= '0;
      d_q  <= '0;
    end else begin
      wr_q <= wr_act;
      if (wr_act && !wr_q) a_q <= bus_addr;
      if (wr_act) d_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      id_mode_o  <= 1'b0;
      op_start_o <= 1'b0;
      op_kind_o  <= 2'd0;
      op_addr_o  <= '0;
      op_data_o  <= '0;
    end else begin
      op_start_o <= 1'b0;
      if (commit && !busy_i) begin
        if (st != S_PGM && lo == 8'hF0) begin
          st        <= S_IDLE;
          id_mode_o <= 1'b0;
        end else begin
          st <= S_IDLE;
          case (st)
            S_IDLE: if (at5 && lo == 8'hAA) st <= S_C1;
                    else id_mode_o <= 1'b0;
            S_C1:   if (at2 && lo == 8'h55) st <= S_C2;
                    else id_mode_o <= 1'b0;
            S_C2:   if (at5 && lo == 8'hA0) st <= S_PGM;
                    else if (at5 && lo == 8'h80) st <= S_E3;
                    else if (at5 && lo == 8'h90) id_mode_o <= 1'b1;
                    else id_mode_o <= 1'b0;
            S_PGM: begin
              op_start_o <= 1'b1;
              op_kind_o  <= 2'd0;
              op_addr_o  <= a_q;
              op_data_o  <= d_q;
            end
            S_E3:   if (at5 && lo == 8'hAA) st <= S_E4;
                    else id_mode_o <= 1'b0;
            S_E4:   if (at2 && lo == 8'h55) st <= S_E5;
                    else id_mode_o <= 1'b0;
            S_E5: begin
              if (at5 && lo == 8'h10) begin
                op_start_o <= 1'b1;
                op_kind_o  <= 2'd3;
                op_addr_o  <= '0;
              end else if (lo == 8'h30) begin
                op_start_o <= 1'b1;
                op_kind_o  <= 2'd1;
                op_addr_o  <= {a_q[AW-1:SECT_LSB], {SECT_LSB{1'b0}}};
              end else if (lo == 8'h50) begin
                op_start_o <= 1'b1;
                op_kind_o  <= 2'd2;
                op_addr_o  <= {a_q[AW-1:BLK_LSB], {BLK_LSB{1'b0}}};
              end else id_mode_o <= 1'b0;
            end
            default: id_mode_o <= 1'b0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int AW = 18,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_ce_n,
  input logic          bus_we_n,
  input logic          bus_oe_n,
  input logic          busy_i,
  input logic          op_start_o,
  input logic [1:0]    op_kind_o,
  input logic [AW-1:0] op_addr_o,
  input logic          id_mode_o
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_start_o |=> !op_start_o); // R10
  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    op_start_o |-> !$past(busy_i)); // R8
  AST_BUSY_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(id_mode_o)); // R8
  AST_START_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_start_o |-> $past(bus_we_n || bus_ce_n || !bus_oe_n)); // R1
  AST_SECT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start_o && op_kind_o == 2'd1) |-> op_addr_o[SECT_LSB-1:0] == '0); // R4
  AST_BLK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start_o && op_kind_o == 2'd2) |-> op_addr_o[BLK_LSB-1:0] == '0); // R4
  AST_CHIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start_o && op_kind_o == 2'd3) |-> op_addr_o == '0); // R4
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.AW(AW), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
  .bus_oe_n(bus_oe_n), .busy_i(busy_i), .op_start_o(op_start_o),
  .op_kind_o(op_kind_o), .op_addr_o(op_addr_o), .id_mode_o(id_mode_o)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic start, idm;
  logic [1:0] kind;
  logic [17:0] oaddr;
  logic [15:0] odata, idr;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
    .bus_addr(addr), .bus_wdata(wdata), .busy_i(busy), .op_start_o(start),
    .op_kind_o(kind), .op_addr_o(oaddr), .op_data_o(odata), .id_mode_o(idm),
    .id_rdata_o(idr)
  );

  localparam int NV = 44;
  // {addr, data, exp_start, exp_kind, exp_addr, exp_id}
  localparam logic [55:0] VEC [NV] = '{
    {18'h05555,16'h00AA,1'b0,2'd0,18'h0,1'b0},
    {18'h02AAA,16'h0055,1'b0,2'd0,18'h0,1'b0},
    {18'h05555,16'h00A0,1'b0,2'd0,18'h0,1'b0},
    {18'h12345,16'hBEEF,1'b1,2'd0,18'h12345,1'b0},
    {18'h05555,16'h00AA,1'b0,2'd0,18'h0,1'b0},
    {18'h02AAA,16'h0055,1'b0,2'd0,18'h0,1'b0},
    {18'h05555,16'h0080,1'b0,2'd0,18'h0,1'b0},
    {18'h05555,16'h00AA,1'b0,2'd0,18'h0,1'b0},
    {18'h02AAA,16'h0055,1'b0,2'd0,18'h0,1'b0},
    {18'h2ABCD,16'h0030,1'b1,2'd1,18'h2A800,1'b0},
    {18'h05555,16'h00AA,1'b0,2'd0,18'h0,1'b0},
    {18'h02AAA,16'h0055,1'b0,2'd0,18'h0,1'b0},
    {18'h05555,16'h0080,1'b0,2'd0,18'h0,1'b0},
    {18'h05555,16'h00AA,1'b0,2'd0,18'h0,1'b0},
    {18'h02AAA,16'h0055,1'b0,2'd0,18'h0,1'b0},
    {18'h2ABCD,16'h0050,1'b1,2'd2,18'h28000,1'b0},
    {18'h05555,16'h00AA,1'b0,2'd0,18'h0,1'b0},
    {18'h02AAA,16'h0055,1'b0,2'd0,18'h0,1'b0},
    {18'h05555,16'h0080,1'b0,2'd0,18'h0,1'b0},
    {18'h05555,16'h00AA,1'b0,2'd0,18'h0,1'b0},
    {18'h02AAA,16'h0055,1'b0,2'd0,18'h0,1'b0},
    {18'h05555,16'h0010,1'b1,2'd3,18'h0,1'b0},
    {18'h3D555,16'h12AA,1'b0,2'd0,18'h0,1'b0},
    {18'h0AAAA,16'hFF55,1'b0,2'd0,18'h0,1'b0},
    {18'h05555,16'h34A0,1'b0,2'd0,18'h0,1'b0},
    {18'h00007,16'h00FF,1'b1,2'd0,18'h00007,1'b0},
    {18'h05555,16'h00AA,1'b0,2'd0,18'h0,1'b0},
    {18'h02AAA,16'h0066,1'b0,2'd0,18'h0,1'b0},
    {18'h05555,16'h00A0,1'b0,2'd0,18'h0,1'b0},
    {18'h00001,16'h1111,1'b0,2'd0,18'h0,1'b0},
    {18'h05555,16'h00AA,1'b0,2'd0,18'h0,1'b0},
    {18'h02AAA,16'h0055,1'b0,2'd0,18'h0,1'b0},
    {18'h05555,16'h0090,1'b0,2'd0,18'h0,1'b1},
    {18'h01234,16'h00F0,1'b0,2'd0,18'h0,1'b0},
    {18'h05555,16'h00AA,1'b0,2'd0,18'h0,1'b0},
    {18'h02AAA,16'h0055,1'b0,2'd0,18'h0,1'b0},
    {18'h05555,16'h0090,1'b0,2'd0,18'h0,1'b1},
    {18'h05555,16'h00AA,1'b0,2'd0,18'h0,1'b1},
    {18'h02AAA,16'h0055,1'b0,2'd0,18'h0,1'b1},
    {18'h05555,16'h00F0,1'b0,2'd0,18'h0,1'b0},
    {18'h05555,16'h00AA,1'b0,2'd0,18'h0,1'b0},
    {18'h02AAA,16'h0055,1'b0,2'd0,18'h0,1'b0},
    {18'h05555,16'h0090,1'b0,2'd0,18'h0,1'b1},
    {18'h00000,16'h0000,1'b0,2'd0,18'h0,1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one write; returns at the sampling point one cycle after release
  task automatic wr(input logic [17:0] a, input logic [15:0] d, input logic ce, input logic oe);
    @(negedge clk);
    addr = a; wdata = d; ce_n = ce; oe_n = oe; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(18'h05555, 16'h00AA, 1'b0, 1'b1);
    wr(18'h02AAA, 16'h0055, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(start == 1'b0, "R9 start after reset", start, 0);
    chk(idm == 1'b0, "R9 id after reset", idm, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      v = VEC[i];
      wr(v[55:38], v[37:22], 1'b0, 1'b1);
      chk(start == v[21], $sformatf("R2/R3/R4/R7 start vec%0d", i), start, v[21]);
      if (v[21]) begin
        chk(kind == v[20:19], $sformatf("R3/R4 kind vec%0d", i), kind, v[20:19]);
        chk(oaddr == v[18:1], $sformatf("R3/R4 addr vec%0d", i), oaddr, v[18:1]);
        if (v[20:19] == 2'd0)
          chk(odata == v[37:22], $sformatf("R3 data vec%0d", i), odata, v[37:22]);
      end
      chk(idm == v[0], $sformatf("R5/R6/R7 id vec%0d", i), idm, v[0]);
    end

    // R10 pulse width
    unlock(); wr(18'h05555, 16'h00A0, 1'b0, 1'b1); wr(18'h00100, 16'h5A5A, 1'b0, 1'b1);
    chk(start == 1'b1, "R10 start high", start, 1);
    @(negedge clk);
    chk(start == 1'b0, "R10 start one cycle", start, 0);

    // R5 identification reads
    unlock(); wr(18'h05555, 16'h0090, 1'b0, 1'b1);
    ce_n = 1'b0; oe_n = 1'b0; addr = 18'h00000; #1;
    chk(idr == 16'h00BF, "R5 id offset0", idr, 16'h00BF);
    addr = 18'h00001; #1;
    chk(idr == 16'h2780, "R5 id offset1", idr, 16'h2780);
    ce_n = 1'b1; oe_n = 1'b1;

    // R8 busy: id exit ignored, program ignored
    busy = 1'b1;
    wr(18'h00000, 16'h00F0, 1'b0, 1'b1);
    chk(idm == 1'b1, "R8 exit ignored while busy", idm, 1);
    unlock(); wr(18'h05555, 16'h00A0, 1'b0, 1'b1); wr(18'h00200, 16'h1234, 1'b0, 1'b1);
    chk(start == 1'b0, "R8 program ignored while busy", start, 0);
    busy = 1'b0;
    wr(18'h00000, 16'h00F0, 1'b0, 1'b1);
    chk(idm == 1'b0, "R6 exit after busy", idm, 0);
    wr(18'h00200, 16'h1234, 1'b0, 1'b1);
    chk(start == 1'b0, "R8 state untouched while busy", start, 0);

    // R1 unqualified writes have no effect
    unlock();
    wr(18'h05555, 16'h00A0, 1'b0, 1'b0);
    wr(18'h05555, 16'h00A0, 1'b1, 1'b1);
    wr(18'h05555, 16'h00A0, 1'b0, 1'b1);
    // R1 address from first cycle, data from last cycle
    @(negedge clk);
    addr = 18'h00ABC; wdata = 16'h1111; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    addr = 18'h00DEF; wdata = 16'h2222;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
    chk(start == 1'b1, "R1 start after ignored writes", start, 1);
    chk(oaddr == 18'h00ABC, "R1 address first cycle", oaddr, 18'h00ABC);
    chk(odata == 16'h2222, "R1 data last cycle", odata, 16'h2222);

    // R9 id mode cleared by reset
    unlock(); wr(18'h05555, 16'h0090, 1'b0, 1'b1);
    chk(idm == 1'b1, "R5 id set before reset", idm, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(idm == 1'b0, "R9 id cleared by reset", idm, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule